// File: doc/BRIEF.md
# Supervisor Control-Register and Trap-Redirect Unit

This block sits beside the execute stage of a small in-order core. It owns a compact set of control and status registers and runs the register instructions that read a register and replace or set bits in it. It also computes where the program counter goes after a system call or after a return from a machine-level or supervisor-level trap. Each request is a single-cycle strobe that carries an operation code, a 12-bit register address, a source operand and the program counter of the issuing instruction.

Results come out one clock after the request. The old register value goes to `rd_value` for the destination register. A redirect target goes to `redirect_pc` and is qualified by a one-cycle `redirect_valid` pulse. A rejected request gives a one-cycle `err` pulse. The current page-table root is driven at all times for the address-translation logic. Only six addresses have storage. Thirteen more read as zero and cannot be written, and every other address is rejected.

The control is a four-state machine whose state register records how the previous cycle's request ended. `ST_IDLE` is entered whenever no request is strobed. `ST_ACCESS` is entered after a register request that was accepted. `ST_REDIRECT` is entered after a system call or a trap return. `ST_FAULT` is entered after a rejected register request or a reserved operation code. Every state can move to any state on the next request, so back-to-back requests each get their own result cycle.

Top module: `sup_csr_trap_unit`

## Requirements
- R1: After reset, every stored register and the page-table root are zero, `rd_value` and `redirect_pc` are zero, and `redirect_valid` and `err` are low.
- R2: A read-write request (op 0) to a stored register returns the register's previous value on `rd_value` and replaces it with the operand. The stored registers are 0x105 trap vector, 0x140 scratch, 0x141 trap PC, 0x142 trap cause, 0x180 translation control and 0x341 machine return PC.
- R3: A read-set request (op 1) returns the previous value and stores the previous value ORed with the operand. A read-set with a zero operand is a pure read and attempts no write.
- R4: Addresses 0x100, 0x104, 0x14d, 0x300, 0x302, 0x303, 0x304, 0x306, 0x30a, 0x3a0, 0x3b0, 0xc01 and 0xf14 return zero to a pure read without raising `err`.
- R5: A register request to any address not listed in R2 or R4 raises `err` one cycle later and leaves `rd_value` and all stored state unchanged.
- R6: A write attempt to an address listed in R4 (op 0, or op 1 with a non-zero operand) raises `err` and changes nothing.
- R7: A write of value V to 0x180 whose bits 63:60 equal 8 sets the root to V shifted left by 12. A write of zero clears the root. Any other value raises `err` and keeps the root. The root's low 12 bits are always zero.
- R8: A read of 0x180 returns the root shifted right by 12, with 8 in bits 63:60 when the root is non-zero.
- R9: A system call (op 2) stores the request PC into 0x141 and 8 into 0x142, and redirects to the 0x105 value with its low two bits cleared.
- R10: A machine return (op 3) redirects to the 0x341 value. A supervisor return (op 4) redirects to the 0x141 value. Neither changes stored state.
- R11: `redirect_valid` and `err` are one-cycle pulses, one per request, in the cycle after the request, and never high together. `rd_value` and `redirect_pc` hold until the next accepted request of their kind.
- R12: Operation codes 5, 6 and 7 are reserved. They raise `err` and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | 0 read-write, 1 read-set, 2 system call, 3 machine return, 4 supervisor return |
| req_csr_addr | input | 12 | Register address |
| req_operand | input | XLEN | Source operand |
| req_pc | input | XLEN | PC of the issuing instruction |
| rd_value | output | XLEN | Previous register value of the last accepted register request |
| redirect_valid | output | 1 | Redirect pulse |
| redirect_pc | output | XLEN | Next PC for the last redirect |
| err | output | 1 | Rejected-request pulse |
| pt_root | output | XLEN | Current page-table root, zero when translation is off |

## Verification
Every result of a request taken at one rising edge is due just after that edge. This covers the old value, the redirect pulse and target, the error pulse and an updated page-table root. A request's side effects on stored registers show up through a read request issued in any later cycle. The bench drives each request on a falling edge and lets one rising edge pass. It then compares every output against its behavioural model at the next falling edge. Idle cycles are compared the same way, which catches pulses that last too long and held values that drift.

// File: rtl/sct_pkg.sv
package sct_pkg;

    typedef enum logic [2:0] {
        OP_RW      = 3'd0,
        OP_RS      = 3'd1,
        OP_SYSCALL = 3'd2,
        OP_RET_M   = 3'd3,
        OP_RET_S   = 3'd4
    } sct_op_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ZERO  = 2'd1,
        CLS_STORE = 2'd2
    } sct_cls_e;

    typedef enum logic [2:0] {
        SLOT_VEC    = 3'd0,
        SLOT_SCRACH = 3'd1,
        SLOT_TPC    = 3'd2,
        SLOT_CAUSE  = 3'd3,
        SLOT_XLAT   = 3'd4,
        SLOT_MRPC   = 3'd5
    } sct_slot_e;

    localparam int NUM_SLOTS = 6;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ACCESS   = 2'd1,
        ST_REDIRECT = 2'd2,
        ST_FAULT    = 2'd3
    } sct_state_e;

    localparam logic [11:0] A_VEC    = 12'h105;
    localparam logic [11:0] A_SCRACH = 12'h140;
    localparam logic [11:0] A_TPC    = 12'h141;
    localparam logic [11:0] A_CAUSE  = 12'h142;
    localparam logic [11:0] A_XLAT   = 12'h180;
    localparam logic [11:0] A_MRPC   = 12'h341;

    localparam logic [3:0] XLAT_MODE_ON    = 4'h8;
    localparam int         CALL_CAUSE_CODE = 8;

endpackage

// File: rtl/sct_addr_decode.sv
module sct_addr_decode
    import sct_pkg::*;
(
    input  logic [11:0] addr,
    output sct_cls_e    cls,
    output sct_slot_e   slot
);

    always_comb begin
        cls  = CLS_STORE;
        slot = SLOT_VEC;
        case (addr)
            A_VEC:    slot = SLOT_VEC;
            A_SCRACH: slot = SLOT_SCRACH;
            A_TPC:    slot = SLOT_TPC;
            A_CAUSE:  slot = SLOT_CAUSE;
            A_XLAT:   slot = SLOT_XLAT;
            A_MRPC:   slot = SLOT_MRPC;
            12'h100, 12'h104, 12'h14d, 12'h300, 12'h302, 12'h303,
            12'h304, 12'h306, 12'h30a, 12'h3a0, 12'h3b0, 12'hc01,
            12'hf14:  cls = CLS_ZERO;
            default:  cls = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/sct_slot_file.sv
module sct_slot_file
    import sct_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  sct_slot_e       wr_slot,
    input  logic [XLEN-1:0] wr_data,
    input  logic            call_en,
    input  logic [XLEN-1:0] call_pc,
    input  sct_slot_e       rd_slot,
    output logic [XLEN-1:0] rd_data,
    output logic [XLEN-1:0] vec_q,
    output logic [XLEN-1:0] tpc_q,
    output logic [XLEN-1:0] mrpc_q,
    output logic [XLEN-1:0] root_q
);

    logic [XLEN-1:0] slots [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam sct_slot_e THIS = sct_slot_e'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots[g] <= '0;
            end else if (call_en && THIS == SLOT_TPC) begin
                slots[g] <= call_pc;
            end else if (call_en && THIS == SLOT_CAUSE) begin
                slots[g] <= XLEN'(CALL_CAUSE_CODE);
            end else if (wr_en && wr_slot == THIS) begin
                slots[g] <= wr_data;
            end
        end
    end

    assign rd_data = slots[rd_slot];
    assign vec_q   = slots[SLOT_VEC];
    assign tpc_q   = slots[SLOT_TPC];
    assign mrpc_q  = slots[SLOT_MRPC];
    assign root_q  = slots[SLOT_XLAT];

endmodule

// File: rtl/sct_value_path.sv
module sct_value_path
    import sct_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [2:0]      op,
    input  sct_cls_e        cls,
    input  sct_slot_e       slot,
    input  logic [XLEN-1:0] raw_old,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] view_old,
    output logic            wr_attempt,
    output logic            accept,
    output logic [XLEN-1:0] store_val
);

    localparam int MODE_W = 4;
    localparam logic [XLEN-1:0] MODE_FIELD = {XLAT_MODE_ON, {(XLEN-MODE_W){1'b0}}};

    logic [XLEN-1:0] new_val;
    logic            is_xlat;
    logic            mode_on;
    logic            xlat_ok;

    assign is_xlat = (slot == SLOT_XLAT);

    always_comb begin
        if (cls != CLS_STORE) begin
            view_old = '0;
        end else if (is_xlat) begin
            view_old = (raw_old >> PAGE_SHIFT) | ((raw_old != '0) ? MODE_FIELD : '0);
        end else begin
            view_old = raw_old;
        end
    end

    assign new_val    = (op == OP_RS) ? (view_old | operand) : operand;
    assign wr_attempt = (op == OP_RW) || ((op == OP_RS) && (operand != '0));
    assign mode_on    = (new_val[XLEN-1 -: MODE_W] == XLAT_MODE_ON);
    assign xlat_ok    = !is_xlat || mode_on || (new_val == '0);

    assign accept = (cls != CLS_NONE) &&
                    (!wr_attempt || ((cls == CLS_STORE) && xlat_ok));

    assign store_val = !is_xlat ? new_val :
                       mode_on  ? (new_val << PAGE_SHIFT) : '0;

endmodule

// File: rtl/sup_csr_trap_unit.sv
module sup_csr_trap_unit
    import sct_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [11:0]     req_csr_addr,
    input  logic [XLEN-1:0] req_operand,
    input  logic [XLEN-1:0] req_pc,
    output logic [XLEN-1:0] rd_value,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic            err,
    output logic [XLEN-1:0] pt_root
);

    sct_cls_e        cls;
    sct_slot_e       slot;
    logic [XLEN-1:0] raw_old;
    logic [XLEN-1:0] view_old;
    logic [XLEN-1:0] store_val;
    logic            wr_attempt;
    logic            accept;
    logic [XLEN-1:0] vec_q;
    logic [XLEN-1:0] tpc_q;
    logic [XLEN-1:0] mrpc_q;
    logic [XLEN-1:0] target;
    logic            is_reg_op;
    logic            is_flow_op;
    logic            wr_en;
    logic            call_en;
    sct_state_e      state_q;
    sct_state_e      state_d;

    assign is_reg_op  = (req_op == OP_RW) || (req_op == OP_RS);
    assign is_flow_op = (req_op == OP_SYSCALL) || (req_op == OP_RET_M) ||
                        (req_op == OP_RET_S);
    assign wr_en      = req_valid && is_reg_op && accept && wr_attempt;
    assign call_en    = req_valid && (req_op == OP_SYSCALL);

    sct_addr_decode u_decode (
        .addr (req_csr_addr),
        .cls  (cls),
        .slot (slot)
    );

    sct_slot_file #(.XLEN(XLEN)) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (slot),
        .wr_data (store_val),
        .call_en (call_en),
        .call_pc (req_pc),
        .rd_slot (slot),
        .rd_data (raw_old),
        .vec_q   (vec_q),
        .tpc_q   (tpc_q),
        .mrpc_q  (mrpc_q),
        .root_q  (pt_root)
    );

    sct_value_path #(.XLEN(XLEN), .PAGE_SHIFT(PAGE_SHIFT)) u_value (
        .op         (req_op),
        .cls        (cls),
        .slot       (slot),
        .raw_old    (raw_old),
        .operand    (req_operand),
        .view_old   (view_old),
        .wr_attempt (wr_attempt),
        .accept     (accept),
        .store_val  (store_val)
    );

    always_comb begin
        unique case (req_op)
            OP_RET_M: target = mrpc_q;
            OP_RET_S: target = tpc_q;
            default:  target = {vec_q[XLEN-1:2], 2'b00};
        endcase
    end

    // Next-state selection: the state names the outcome of this cycle's request.
    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;
        end else if (is_reg_op) begin
            state_d = accept ? ST_ACCESS : ST_FAULT;
        end else if (is_flow_op) begin
            state_d = ST_REDIRECT;
        end else begin
            state_d = ST_FAULT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            rd_value    <= '0;
            redirect_pc <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_ACCESS) begin
                rd_value <= view_old;
            end
            if (state_d == ST_REDIRECT) begin
                redirect_pc <= target;
            end
        end
    end

    always_comb begin
        redirect_valid = 1'b0;
        err            = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_ACCESS:   ;
            ST_REDIRECT: redirect_valid = 1'b1;
            ST_FAULT:    err = 1'b1;
        endcase
    end

endmodule

// File: rtl/sct_checker.sv
module sct_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      req_op,
    input logic [XLEN-1:0] rd_value,
    input logic            redirect_valid,
    input logic            err,
    input logic [XLEN-1:0] pt_root
);

    a_r11_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect_valid && err));

    a_r11_redirect_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> ($past(req_valid) && ($past(req_op) inside {3'd2, 3'd3, 3'd4})));

    a_r11_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(req_valid));

    a_r9_call_redirects: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd2) |=> redirect_valid);

    a_r12_reserved_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op > 3'd4) |=> err);

    a_r7_root_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pt_root[11:0] == 12'h000);

    a_r7_root_needs_reg_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_op <= 3'd1) |=> $stable(pt_root));

    a_r11_rd_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rd_value));

endmodule

bind sup_csr_trap_unit sct_checker #(.XLEN(XLEN)) u_sct_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_op         (req_op),
    .rd_value       (rd_value),
    .redirect_valid (redirect_valid),
    .err            (err),
    .pt_root        (pt_root)
);

// File: tb/sup_csr_trap_unit_tb_top.sv
module sup_csr_trap_unit_tb_top;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2:0]      req_op = '0;
    logic [11:0]     req_csr_addr = '0;
    logic [XLEN-1:0] req_operand = '0;
    logic [XLEN-1:0] req_pc = '0;
    logic [XLEN-1:0] rd_value;
    logic            redirect_valid;
    logic [XLEN-1:0] redirect_pc;
    logic            err;
    logic [XLEN-1:0] pt_root;

    always #4 clk = ~clk;

    sup_csr_trap_unit #(.XLEN(XLEN)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_op         (req_op),
        .req_csr_addr   (req_csr_addr),
        .req_operand    (req_operand),
        .req_pc         (req_pc),
        .rd_value       (rd_value),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .err            (err),
        .pt_root        (pt_root)
    );

    // Behavioural reference state
    logic [63:0] m_vec = 0, m_scr = 0, m_tpc = 0, m_cause = 0, m_root = 0, m_mrpc = 0;
    logic [63:0] e_rd = 0, e_rpc = 0;
    bit          e_rv = 0, e_err = 0;
    int          vectors = 0;
    int          miscompares = 0;
    bit          finished = 0;

    task automatic lookup(input logic [11:0] a, output bit known, output bit ro,
                          output logic [63:0] v);
        known = 1; ro = 0; v = 0;
        case (a)
            12'h105: v = m_vec;
            12'h140: v = m_scr;
            12'h141: v = m_tpc;
            12'h142: v = m_cause;
            12'h341: v = m_mrpc;
            12'h180: v = (m_root >> 12) | ((m_root != 0) ? (64'h8 << 60) : 64'h0);
            12'h100, 12'h104, 12'h14d, 12'h300, 12'h302, 12'h303, 12'h304,
            12'h306, 12'h30a, 12'h3a0, 12'h3b0, 12'hc01, 12'hf14: ro = 1;
            default: known = 0;
        endcase
    endtask

    task automatic store(input logic [11:0] a, input logic [63:0] v);
        case (a)
            12'h105: m_vec = v;
            12'h140: m_scr = v;
            12'h141: m_tpc = v;
            12'h142: m_cause = v;
            12'h341: m_mrpc = v;
            12'h180: m_root = (v == 0) ? 64'h0 : (v << 12);
            default: ;
        endcase
    endtask

    task automatic compare(input string tag);
        bit bad = 0;
        vectors++;
        if (rd_value !== e_rd) begin
            $display("FAIL %s rd_value actual=%h expected=%h", tag, rd_value, e_rd); bad = 1;
        end
        if (redirect_valid !== e_rv) begin
            $display("FAIL %s redirect_valid actual=%b expected=%b", tag, redirect_valid, e_rv); bad = 1;
        end
        if (redirect_pc !== e_rpc) begin
            $display("FAIL %s redirect_pc actual=%h expected=%h", tag, redirect_pc, e_rpc); bad = 1;
        end
        if (err !== e_err) begin
            $display("FAIL %s err actual=%b expected=%b", tag, err, e_err); bad = 1;
        end
        if (pt_root !== m_root) begin
            $display("FAIL %s pt_root actual=%h expected=%h", tag, pt_root, m_root); bad = 1;
        end
        if (bad) miscompares++;
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(input bit v, input logic [2:0] op, input logic [11:0] a,
                        input logic [63:0] d, input logic [63:0] pc, input string tag);
        bit known, ro, wr, bad;
        logic [63:0] old, nv;
        req_valid = v; req_op = op; req_csr_addr = a; req_operand = d; req_pc = pc;
        e_rv = 0; e_err = 0;
        if (v) begin
            case (op)
                3'd0, 3'd1: begin
                    lookup(a, known, ro, old);
                    nv  = (op == 3'd1) ? (old | d) : d;
                    wr  = (op == 3'd0) || (d != 0);
                    bad = !known || (wr && ro) ||
                          (wr && a == 12'h180 && nv[63:60] != 4'h8 && nv != 0);
                    if (bad) e_err = 1;
                    else begin
                        e_rd = old;
                        if (wr) store(a, nv);
                    end
                end
                3'd2: begin
                    e_rv = 1; e_rpc = m_vec & ~64'h3;
                    m_tpc = pc; m_cause = 64'd8;
                end
                3'd3: begin e_rv = 1; e_rpc = m_mrpc; end
                3'd4: begin e_rv = 1; e_rpc = m_tpc; end
                default: e_err = 1;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 3'd0, 12'h000, 64'h0, 64'h0, tag);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            $display("FAIL watchdog expired actual=running expected=done");
            miscompares++;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [11:0] zero_list [13];
        logic [11:0] store_list [5];
        zero_list = '{12'h100, 12'h104, 12'h14d, 12'h300, 12'h302, 12'h303, 12'h304,
                      12'h306, 12'h30a, 12'h3a0, 12'h3b0, 12'hc01, 12'hf14};
        store_list = '{12'h105, 12'h140, 12'h141, 12'h142, 12'h341};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset state");

        // R2: write then read back each plain stored register
        for (int i = 0; i < 5; i++) begin
            step(1, 3'd0, store_list[i], 64'hA5A5_0000_0000_1000 + 64'(i * 17), 0, "R2 write");
            step(1, 3'd0, store_list[i], 64'h0000_0000_0000_1003 + 64'(i * 4), 0, "R2 swap");
        end
        // R3: read-set ORs bits, zero operand is a pure read
        step(1, 3'd1, 12'h105, 64'h0, 0, "R3 pure read");
        step(1, 3'd1, 12'h105, 64'h30, 0, "R3 set bits");
        step(1, 3'd1, 12'h105, 64'h0, 0, "R3 read after set");
        idle("R11 rd_value held");

        // R4: read-as-zero registers
        for (int i = 0; i < 13; i++) step(1, 3'd1, zero_list[i], 64'h0, 0, "R4 zero read");

        // R6: write attempts to read-only registers
        step(1, 3'd0, 12'h300, 64'h5, 0, "R6 rw to read-only");
        step(1, 3'd1, 12'h104, 64'h1, 0, "R6 set to read-only");
        step(1, 3'd1, 12'h140, 64'h0, 0, "R6 state unchanged");

        // R5: unlisted addresses
        step(1, 3'd1, 12'h123, 64'h0, 0, "R5 unlisted read");
        step(1, 3'd0, 12'h7ff, 64'hFFFF, 0, "R5 unlisted write");
        idle("R5 rd_value unchanged");

        // R7 / R8: translation control
        step(1, 3'd0, 12'h180, (64'h8 << 60) | 64'h12345, 0, "R7 enable root");
        step(1, 3'd1, 12'h180, 64'h0, 0, "R8 read root");
        step(1, 3'd0, 12'h180, (64'h5 << 60) | 64'h1, 0, "R7 bad mode");
        step(1, 3'd1, 12'h180, 64'h0, 0, "R8 root kept");
        step(1, 3'd0, 12'h180, 64'h0, 0, "R7 disable");
        step(1, 3'd1, 12'h180, 64'h0, 0, "R8 read disabled");
        step(1, 3'd1, 12'h180, 64'h40, 0, "R7 set without mode");
        step(1, 3'd1, 12'h180, 64'h8 << 60, 0, "R7 set mode only");

        // R9: system call
        step(1, 3'd0, 12'h105, 64'h0000_0000_8000_2007, 0, "R9 vector setup");
        step(1, 3'd2, 12'h000, 64'h0, 64'h0000_0000_0000_4444, "R9 call redirect");
        idle("R11 redirect pulse ends");
        step(1, 3'd1, 12'h141, 64'h0, 0, "R9 saved pc");
        step(1, 3'd1, 12'h142, 64'h0, 0, "R9 cause");

        // R10: trap returns
        step(1, 3'd0, 12'h341, 64'h0000_0000_0000_9abc, 0, "R10 return pc setup");
        step(1, 3'd3, 12'h000, 64'h0, 0, "R10 machine return");
        step(1, 3'd4, 12'h000, 64'h0, 0, "R10 supervisor return");

        // R11: back-to-back flow requests then idle
        step(1, 3'd2, 12'h000, 64'h0, 64'h0000_0000_0000_0100, "R11 back-to-back call");
        step(1, 3'd3, 12'h000, 64'h0, 0, "R11 back-to-back return");
        step(1, 3'd0, 12'h999, 64'h1, 0, "R11 fault after redirect");
        idle("R11 pulses clear");

        // R12: reserved operation codes
        for (int i = 5; i < 8; i++) step(1, 3'(i), 12'h140, 64'h77, 0, "R12 reserved op");
        step(1, 3'd1, 12'h140, 64'h0, 0, "R12 state unchanged");
        idle("R12 final idle");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule